// File: doc/BRIEF.md
# Selectable Parity Link with Seven-Segment Display

This combinational block demonstrates a parity-protected link. It takes two 4-bit data words from a 10-bit switch bus and picks one of them. It computes a parity bit for the chosen word and appends it below the data bits to form a 5-bit message. A checker that receives this message reports whether the parity holds.

One mode switch sets the parity polarity, odd or even, for both the generator and the checker at the same time. Four seven-segment digits show the results:

- the selected word, in hex;
- the parity bit;
- the checker's error flag;
- a letter for the active mode.

A LED bus repeats the raw switch settings. The block has no clock or storage, so every output follows the switches directly.

Top module: `parity_link`

## Requirements
- R1: `led[i]` equals `sw[i]` for every bit i and every switch setting.
- R2: When `sw[8]` is 0, the transmitted word is `sw[3:0]`. When `sw[8]` is 1, it is `sw[7:4]`. The word occupies bits 4:1 of the 5-bit message.
- R3: When `sw[9]` is 0 (even mode), the parity bit in message bit 0 is the XOR of the four word bits. When `sw[9]` is 1 (odd mode), it is the inverse of that XOR.
- R4: The checker flags an error as the XOR of all five message bits, inverted in odd mode. The flag value 0 means no error. With the uncorrupted message, the flag is 0 for every one of the 1024 switch settings.
- R5: Segment outputs are active low, with bit 0 as segment a through bit 6 as segment g. `hex0` shows the selected word as a hex glyph for all 16 values. A, C, E and F appear as capitals, and b and d as lower-case shapes.
- R6: `hex1` shows the parity bit as the glyph for 0 or 1.
- R7: `hex2` shows the checker flag as the glyph for 0 or 1.
- R8: `hex3` shows a letter for the active mode:
  - even mode: E, with segments a, d, e, f and g lit;
  - odd mode: O, with segments a, b, c, d, e and f lit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw | input | 10 | Switch bus: word 1 in 3:0, word 2 in 7:4, word select in 8, parity mode in 9 |
| led | output | 10 | Copy of the switch bus |
| hex0 | output | 7 | Selected word glyph, active low |
| hex1 | output | 7 | Parity bit glyph, active low |
| hex2 | output | 7 | Checker flag glyph, active low |
| hex3 | output | 7 | Mode letter glyph, active low |

## Verification
The block holds no state, so an internal fault shows at the ports in the same evaluation as the switch setting that exposes it. A wrong word selection shows up on `hex0`. A wrong polarity shows up as a flipped `hex1` digit. If the generator and checker disagree on polarity, `hex2` shows a 1.

All 1024 switch settings are applied, and each one is compared against values the bench derives itself. Because every setting is covered, a fault on any single path cannot go unseen.

// File: rtl/parity_link_pkg.sv
package parity_link_pkg;
  localparam int WORD_W  = 4;
  localparam int MSG_W   = WORD_W + 1;
  localparam int SW_W    = 2 * WORD_W + 2;
  localparam int SEG_W   = 7;
  localparam int SEL_BIT  = 2 * WORD_W;
  localparam int MODE_BIT = 2 * WORD_W + 1;

  // Active-low glyphs, bit 0 = segment a ... bit 6 = segment g
  localparam logic [SEG_W-1:0] GLYPH_E = ~7'h79;
  localparam logic [SEG_W-1:0] GLYPH_O = ~7'h3F;

  function automatic logic word_xor(input logic [WORD_W-1:0] w);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < WORD_W; i++) acc = acc ^ w[i];
    return acc;
  endfunction

  function automatic logic msg_xor(input logic [MSG_W-1:0] m);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < MSG_W; i++) acc = acc ^ m[i];
    return acc;
  endfunction

  function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] v);
    logic [SEG_W-1:0] lit;
    case (v)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction
endpackage

// File: rtl/word_select.sv
module word_select
  import parity_link_pkg::*;
(
  input  logic [WORD_W-1:0] word_lo,
  input  logic [WORD_W-1:0] word_hi,
  input  logic              pick_hi,
  output logic [WORD_W-1:0] word_out
);
  always_comb word_out = pick_hi ? word_hi : word_lo;
endmodule

// File: rtl/parity_gen.sv
module parity_gen
  import parity_link_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic              odd_mode,
  output logic              par_bit
);
  always_comb par_bit = word_xor(data) ^ odd_mode;
endmodule

// File: rtl/parity_chk.sv
module parity_chk
  import parity_link_pkg::*;
(
  input  logic [MSG_W-1:0] msg,
  input  logic             odd_mode,
  output logic             err
);
  always_comb err = msg_xor(msg) ^ odd_mode;
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import parity_link_pkg::*;
(
  input  logic [3:0]       value,
  output logic [SEG_W-1:0] seg_n
);
  always_comb seg_n = hex_glyph(value);
endmodule

// File: rtl/parity_link.sv
module parity_link
  import parity_link_pkg::*;
(
  input  logic [9:0] sw,
  output logic [9:0] led,
  output logic [6:0] hex0,
  output logic [6:0] hex1,
  output logic [6:0] hex2,
  output logic [6:0] hex3
);
  localparam int DIGITS = 3;

  logic [WORD_W-1:0] sel_word;
  logic              par_bit;
  logic [MSG_W-1:0]  tx_msg;
  logic              chk_err;
  logic              odd_mode;
  logic [3:0]        digit_val [DIGITS];
  logic [SEG_W-1:0]  digit_seg [DIGITS];

  assign odd_mode = sw[MODE_BIT];
  assign led      = sw;

  word_select u_sel (
    .word_lo (sw[WORD_W-1:0]),
    .word_hi (sw[2*WORD_W-1:WORD_W]),
    .pick_hi (sw[SEL_BIT]),
    .word_out(sel_word)
  );

  parity_gen u_gen (
    .data    (sel_word),
    .odd_mode(odd_mode),
    .par_bit (par_bit)
  );

  assign tx_msg = {sel_word, par_bit};

  parity_chk u_chk_path (
    .msg     (tx_msg),
    .odd_mode(odd_mode),
    .err     (chk_err)
  );

  assign digit_val[0] = sel_word;
  assign digit_val[1] = {3'b000, par_bit};
  assign digit_val[2] = {3'b000, chk_err};

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    seg_decode u_dec (
      .value(digit_val[d]),
      .seg_n(digit_seg[d])
    );
  end

  assign hex0 = digit_seg[0];
  assign hex1 = digit_seg[1];
  assign hex2 = digit_seg[2];
  assign hex3 = odd_mode ? GLYPH_O : GLYPH_E;
endmodule

// File: rtl/parity_link_chk.sv
module parity_link_chk (
  input logic [9:0] sw,
  input logic [9:0] led,
  input logic [6:0] hex3,
  input logic [4:0] tx_msg,
  input logic       chk_err
);
  always_comb begin
    if (!$isunknown(sw)) begin
      // R1
      led_mirror_chk: assert (led == sw);
      // R2
      word_route_chk: assert (tx_msg[4:1] == (sw[8] ? sw[7:4] : sw[3:0]));
      // R3
      parity_fit_chk: assert ((^tx_msg) == sw[9]);
      // R4
      no_error_chk: assert (chk_err == 1'b0);
      // R8
      mode_glyph_chk: assert (hex3 == (sw[9] ? 7'b1000000 : 7'b0000110));
    end
  end
endmodule

bind parity_link parity_link_chk u_parity_link_chk (
  .sw     (sw),
  .led    (led),
  .hex3   (hex3),
  .tx_msg (tx_msg),
  .chk_err(chk_err)
);

// File: tb/parity_link_bench.sv
module parity_link_bench;
  logic       clk = 1'b0;
  logic [9:0] sw = '0;
  logic [9:0] led;
  logic [6:0] hex0, hex1, hex2, hex3;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  parity_link u_parity_link (
    .sw(sw), .led(led), .hex0(hex0), .hex1(hex1), .hex2(hex2), .hex3(hex3)
  );

  // Active-low glyph built from per-segment "dark" digit lists
  function automatic logic [6:0] want_glyph(input int v);
    logic [6:0] s;
    s = 7'b1111111;
    if (!(v inside {1, 4, 11, 13}))         s[0] = 1'b0;
    if (!(v inside {5, 6, 11, 12, 14, 15})) s[1] = 1'b0;
    if (!(v inside {2, 12, 14, 15}))        s[2] = 1'b0;
    if (!(v inside {1, 4, 7, 10, 15}))      s[3] = 1'b0;
    if (!(v inside {1, 3, 4, 5, 7, 9}))     s[4] = 1'b0;
    if (!(v inside {1, 2, 3, 7, 13}))       s[5] = 1'b0;
    if (!(v inside {0, 1, 7, 12}))          s[6] = 1'b0;
    return s;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sw=%03h actual=%03h expected=%03h", req, sw, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Initial all-off setting: R1 mirror, R8 even letter E
    check("R1", led, 10'h000);
    check("R8", {3'b0, hex3}, {3'b0, 7'b0000110});
    for (int i = 0; i < 1024; i++) begin
      int word, par;
      logic [6:0] e3;
      @(posedge clk);
      sw = i[9:0];
      @(negedge clk);
      word = i[8] ? (i >> 4) & 15 : i & 15;
      par  = ((word & 1) + ((word >> 1) & 1) + ((word >> 2) & 1) + ((word >> 3) & 1)) % 2;
      if (i[9]) par = 1 - par;
      // R8: O lights a-f, E lights a,d,e,f,g
      e3 = i[9] ? ~7'b0111111 : ~7'b1111001;
      check("R1", led, i[9:0]);
      check("R2_R5", {3'b0, hex0}, {3'b0, want_glyph(word)});
      check("R3_R6", {3'b0, hex1}, {3'b0, want_glyph(par)});
      check("R4_R7", {3'b0, hex2}, {3'b0, want_glyph(0)});
      check("R8", {3'b0, hex3}, {3'b0, e3});
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule